// File: doc/BRIEF.md
# Interrupt Input Line Router and Latch

This block receives one flat vector of interrupt input lines from the rest of the system. It sorts every line into one of two banks. One is a common bank of shared external interrupts. The other is a set of private 32-entry banks, one for each processor. For every interrupt it keeps the most recent level. It latches a pending bit when a line rises and that interrupt is configured as edge-triggered. Software can drop a latched pending bit with a per-interrupt clear strobe.

The lower part of the input vector feeds the shared bank. Line `k` lands in shared slot `k`, which carries interrupt ID `k + 32`. The upper part is split into one group of 32 lines per processor. Within each group, the first 16 positions are reserved for software-generated interrupts and must never be driven from a wire. A level change on one of those lines is dropped, and it raises a one-cycle flag so that wiring mistakes are visible.

Inputs are sampled on every clock. All state is updated in a single register stage, so each output reflects the inputs captured at the previous rising clock edge.

Top module: `irq_line_router`

## Requirements
- R1: Input line `k` with `k < NUM_IRQ-32` drives shared slot `k` (interrupt ID `k+32`), and `shared_level[k]` equals `irq_in[k]` one clock later.
- R2: Input line `k >= NUM_IRQ-32` maps to processor `c = (k-(NUM_IRQ-32))/32` and local ID `j = (k-(NUM_IRQ-32))%32`. Its state appears at bit `c*32+j` of `cpu_level` and `cpu_pend`.
- R3: A line whose sample equals its stored level causes no state change. A changed line updates its stored level at the next clock.
- R4: A 0 to 1 change on a line whose edge-config bit is 1 sets its pending bit, visible one clock later. The bit stays set after the line falls.
- R5: A 1 to 0 change never sets a pending bit. A rising change on a line whose config bit is 0 (level) latches nothing.
- R6: For an interrupt configured as level (config bit 0), the pending output is the latched pending bit OR the stored level. For edge (config bit 1), it is the latched bit alone.
- R7: A clear strobe at 1 drops the latched pending bit at the next clock. If a rising edge on an edge-configured line arrives in the same cycle, the bit stays set.
- R8: Local IDs 0 to 15 of every processor bank hold level 0 and pending 0 whatever their input does. `sgi_line_err` is 1 for exactly the cycle after any such line changes, compared with its previous sample (0 after reset).
- R9: A synchronous active-high `rst` clears every level, pending bit and the flag.
- R10: Processor banks are independent: a line mapped to one processor changes no bit of another processor's bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ-32+NUM_CPU*32 | Flat interrupt input line vector |
| shared_edge_cfg | input | NUM_IRQ-32 | Per shared interrupt: 1 edge, 0 level |
| shared_clr | input | NUM_IRQ-32 | Per shared interrupt pending clear strobe |
| cpu_edge_cfg | input | NUM_CPU*32 | Per private interrupt: 1 edge, 0 level |
| cpu_clr | input | NUM_CPU*32 | Per private interrupt pending clear strobe |
| shared_level | output | NUM_IRQ-32 | Stored level of each shared interrupt |
| shared_pend | output | NUM_IRQ-32 | Pending view of each shared interrupt |
| cpu_level | output | NUM_CPU*32 | Stored level, bank c at bits c*32 upward |
| cpu_pend | output | NUM_CPU*32 | Pending view, bank c at bits c*32 upward |
| sgi_line_err | output | 1 | One-cycle flag: a reserved line changed |

## Verification
Two functions can land in the same cycle: a software clear strobe and a rising edge that sets the very pending bit being cleared. The bench provokes this directly, by raising an edge-configured private line in the same cycle that its clear strobe is high, and the expected result is that the bit stays set. The random phase also produces such collisions on both banks. Every outcome is judged against a bench model that applies "set wins over clear" bit by bit.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int BANK_W = 32;
    localparam int SGI_W  = 16;

    // Bits of a private bank that may be driven from input wires.
    localparam logic [BANK_W-1:0] PRIV_LIVE = {{(BANK_W-SGI_W){1'b1}}, {SGI_W{1'b0}}};

    typedef enum logic [1:0] {
        TGT_SHARED   = 2'd0,
        TGT_PRIVATE  = 2'd1,
        TGT_RESERVED = 2'd2
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e   kind;
        logic [7:0]  cpu;
        logic [15:0] slot;  // shared slot, or local ID inside a private bank
    } line_tgt_t;

    // Where a flat input line index lands.
    function automatic line_tgt_t decode_line(input int line, input int num_irq);
        line_tgt_t t;
        int nshr;
        int off;
        t    = '0;
        nshr = num_irq - BANK_W;
        if (line < nshr) begin
            t.kind = TGT_SHARED;
            t.slot = 16'(line);
        end else begin
            off    = line - nshr;
            t.cpu  = 8'(off / BANK_W);
            t.slot = 16'(off % BANK_W);
            t.kind = ((off % BANK_W) < SGI_W) ? TGT_RESERVED : TGT_PRIVATE;
        end
        return t;
    endfunction

endpackage

// File: rtl/irq_line_map.sv
module irq_line_map
    import irq_route_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2
) (
    input  logic [NUM_IRQ-BANK_W+NUM_CPU*BANK_W-1:0] irq_in,
    output logic [NUM_IRQ-BANK_W-1:0]                shr_o,
    output logic [NUM_CPU*BANK_W-1:0]                prv_o,
    output logic [NUM_CPU*SGI_W-1:0]                 rsv_o
);
    localparam int NLINE = NUM_IRQ - BANK_W + NUM_CPU * BANK_W;

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        localparam line_tgt_t T = decode_line(i, NUM_IRQ);
        localparam int CPU_I  = int'(T.cpu);
        localparam int SLOT_I = int'(T.slot);
        if (T.kind == TGT_SHARED) begin : g_shr
            assign shr_o[SLOT_I] = irq_in[i];
        end else if (T.kind == TGT_PRIVATE) begin : g_prv
            assign prv_o[CPU_I*BANK_W + SLOT_I] = irq_in[i];
        end else begin : g_rsv
            assign rsv_o[CPU_I*SGI_W + SLOT_I] = irq_in[i];
        end
    end

    // Reserved positions of each private bank are never wired.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_tie
        assign prv_o[c*BANK_W +: SGI_W] = '0;
    end

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] LIVE  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_in,
    input  logic [WIDTH-1:0] edge_cfg,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] pend_o
);
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] pend_d;

    // Only a 0->1 change of an edge-configured line latches.
    assign rise   = lvl_in & ~level_q & edge_cfg & LIVE;
    // A set in the same cycle wins over a clear.
    assign pend_d = ((pend_q & ~clr) | rise) & LIVE;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            pend_q  <= '0;
        end else begin
            level_q <= lvl_in & LIVE;
            pend_q  <= pend_d;
        end
    end

    assign level_o = level_q;
    assign pend_o  = (edge_cfg & pend_q) | (~edge_cfg & (pend_q | level_q));

endmodule

// File: rtl/irq_rsv_watch.sv
module irq_rsv_watch #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rsv_in,
    output logic             err_o
);
    logic [WIDTH-1:0] prev_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            err_q  <= 1'b0;
        end else begin
            prev_q <= rsv_in;
            err_q  <= |(rsv_in ^ prev_q);
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_route_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [NUM_IRQ-BANK_W+NUM_CPU*BANK_W-1:0] irq_in,
    input  logic [NUM_IRQ-BANK_W-1:0]                shared_edge_cfg,
    input  logic [NUM_IRQ-BANK_W-1:0]                shared_clr,
    input  logic [NUM_CPU*BANK_W-1:0]                cpu_edge_cfg,
    input  logic [NUM_CPU*BANK_W-1:0]                cpu_clr,
    output logic [NUM_IRQ-BANK_W-1:0]                shared_level,
    output logic [NUM_IRQ-BANK_W-1:0]                shared_pend,
    output logic [NUM_CPU*BANK_W-1:0]                cpu_level,
    output logic [NUM_CPU*BANK_W-1:0]                cpu_pend,
    output logic                                     sgi_line_err
);
    localparam int NSHR = NUM_IRQ - BANK_W;
    localparam int NPRV = NUM_CPU * BANK_W;
    localparam int NRSV = NUM_CPU * SGI_W;

    logic [NSHR-1:0] shr_lines;
    logic [NPRV-1:0] prv_lines;
    logic [NRSV-1:0] rsv_lines;

    irq_line_map #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_map (
        .irq_in (irq_in),
        .shr_o  (shr_lines),
        .prv_o  (prv_lines),
        .rsv_o  (rsv_lines)
    );

    irq_latch_bank #(.WIDTH(NSHR)) u_shared (
        .clk      (clk),
        .rst      (rst),
        .lvl_in   (shr_lines),
        .edge_cfg (shared_edge_cfg),
        .clr      (shared_clr),
        .level_o  (shared_level),
        .pend_o   (shared_pend)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        irq_latch_bank #(.WIDTH(BANK_W), .LIVE(PRIV_LIVE)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .lvl_in   (prv_lines[c*BANK_W +: BANK_W]),
            .edge_cfg (cpu_edge_cfg[c*BANK_W +: BANK_W]),
            .clr      (cpu_clr[c*BANK_W +: BANK_W]),
            .level_o  (cpu_level[c*BANK_W +: BANK_W]),
            .pend_o   (cpu_pend[c*BANK_W +: BANK_W])
        );
    end

    irq_rsv_watch #(.WIDTH(NRSV)) u_rsv (
        .clk    (clk),
        .rst    (rst),
        .rsv_in (rsv_lines),
        .err_o  (sgi_line_err)
    );

endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2
) (
    input logic                           clk,
    input logic                           rst,
    input logic [NUM_IRQ-BANK_W-1:0]      shr_lines,
    input logic [NUM_CPU*SGI_W-1:0]       rsv_lines,
    input logic [NUM_IRQ-BANK_W-1:0]      shared_edge_cfg,
    input logic [NUM_IRQ-BANK_W-1:0]      shared_clr,
    input logic [NUM_IRQ-BANK_W-1:0]      shared_level,
    input logic [NUM_IRQ-BANK_W-1:0]      shared_pend,
    input logic [NUM_CPU*BANK_W-1:0]      cpu_level,
    input logic [NUM_CPU*BANK_W-1:0]      cpu_pend,
    input logic                           sgi_line_err
);
    localparam logic [NUM_CPU*BANK_W-1:0] DEAD = ~{NUM_CPU{PRIV_LIVE}};

    logic armed;
    logic armed2;
    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            armed2 <= 1'b0;
        end else begin
            armed  <= 1'b1;
            armed2 <= armed;
        end
    end

    // R3
    level_track_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        shared_level == $past(shr_lines));

    // R4
    rise_sets_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (($past(shr_lines) & ~$past(shared_level) & $past(shared_edge_cfg)
          & shared_edge_cfg & ~shared_pend) == '0));

    // R5
    no_fall_set_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ((shared_pend & ~$past(shared_pend) & shared_edge_cfg & $past(shared_edge_cfg)
          & ~($past(shr_lines) & ~$past(shared_level))) == '0));

    // R6
    level_view_chk: assert property (@(posedge clk) disable iff (rst)
        ((~shared_edge_cfg & shared_level & ~shared_pend) == '0));

    // R7
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (($past(shared_clr) & $past(shared_edge_cfg) & shared_edge_cfg
          & ~($past(shr_lines) & ~$past(shared_level)) & shared_pend) == '0));

    // R8
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (((cpu_level | cpu_pend) & DEAD) == '0));

    // R8
    rsv_flag_chk: assert property (@(posedge clk) disable iff (rst || !armed2)
        ($past(rsv_lines) == $past(rsv_lines, 2)) |-> !sgi_line_err);

endmodule

bind irq_line_router irq_line_router_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .shr_lines       (shr_lines),
    .rsv_lines       (rsv_lines),
    .shared_edge_cfg (shared_edge_cfg),
    .shared_clr      (shared_clr),
    .shared_level    (shared_level),
    .shared_pend     (shared_pend),
    .cpu_level       (cpu_level),
    .cpu_pend        (cpu_pend),
    .sgi_line_err    (sgi_line_err)
);

// File: tb/tb_irq_line_router.sv
`timescale 1ns/1ps
module tb_irq_line_router;
    localparam int NUM_IRQ = 64;
    localparam int NUM_CPU = 2;
    localparam int NS = NUM_IRQ - 32;
    localparam int NP = NUM_CPU * 32;
    localparam int NR = NUM_CPU * 16;
    localparam int NL = NS + NP;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] irq_in = '0;
    logic [NS-1:0] sh_edge = '0, sh_clr = '0;
    logic [NP-1:0] cp_edge = '0, cp_clr = '0;
    logic [NS-1:0] shared_level, shared_pend;
    logic [NP-1:0] cpu_level, cpu_pend;
    logic          sgi_line_err;

    always #2.5 clk = ~clk;

    irq_line_router #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) dut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .shared_edge_cfg(sh_edge), .shared_clr(sh_clr),
        .cpu_edge_cfg(cp_edge), .cpu_clr(cp_clr),
        .shared_level(shared_level), .shared_pend(shared_pend),
        .cpu_level(cpu_level), .cpu_pend(cpu_pend),
        .sgi_line_err(sgi_line_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the state
    logic [NS-1:0] m_shl = '0, m_shp = '0;
    logic [NP-1:0] m_cl = '0, m_cp = '0;
    logic [NR-1:0] m_rsv = '0;
    logic          m_err = 1'b0;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_shl = '0; m_shp = '0; m_cl = '0; m_cp = '0; m_rsv = '0; m_err = 1'b0;
    endtask

    // Next state per the requirements, from the inputs now driven.
    task automatic model_step();
        m_err = 1'b0;
        for (int k = 0; k < NL; k++) begin
            if (k < NS) begin
                m_shp[k] = (m_shp[k] & ~sh_clr[k]) | (irq_in[k] & ~m_shl[k] & sh_edge[k]);
                m_shl[k] = irq_in[k];
            end else begin
                int off = k - NS;
                int c   = off / 32;
                int j   = off % 32;
                if (j < 16) begin
                    if (irq_in[k] != m_rsv[c*16+j]) m_err = 1'b1;
                    m_rsv[c*16+j] = irq_in[k];
                end else begin
                    m_cp[off] = (m_cp[off] & ~cp_clr[off]) | (irq_in[k] & ~m_cl[off] & cp_edge[off]);
                    m_cl[off] = irq_in[k];
                end
            end
        end
    endtask

    task automatic compare_all();
        check("R1 R3 shared_level", 128'(shared_level), 128'(m_shl));
        check("R4 R5 R6 R7 shared_pend", 128'(shared_pend),
              128'((sh_edge & m_shp) | (~sh_edge & (m_shp | m_shl))));
        check("R2 R3 R10 cpu_level", 128'(cpu_level), 128'(m_cl));
        check("R4 R5 R6 R7 R8 cpu_pend", 128'(cpu_pend),
              128'((cp_edge & m_cp) | (~cp_edge & (m_cp | m_cl))));
        check("R8 sgi_line_err", 128'(sgi_line_err), 128'(m_err));
    endtask

    // Inputs are set at a negedge; one edge later the outputs are compared.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        #750000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4711));
        // R9: reset holds everything at zero even with all lines high
        irq_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset levels", 128'({shared_level, cpu_level}), 128'(0));
        check("R9 reset pend", 128'({shared_pend, cpu_pend, sgi_line_err}), 128'(0));
        irq_in = '0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();

        // R1 / R6: shared slot 5, level mode
        irq_in[5] = 1'b1;
        cycle();
        check("R1 slot5 level", 128'(shared_level[5]), 128'(1));
        check("R6 level pend view", 128'(shared_pend[5]), 128'(1));

        // R2 / R4 / R10: processor 1 local ID 20, edge mode
        cp_edge[52] = 1'b1;
        irq_in[NS+32+20] = 1'b1;
        cycle();
        check("R2 cpu1 id20 level", 128'(cpu_level[52]), 128'(1));
        check("R4 cpu1 id20 pend", 128'(cpu_pend[52]), 128'(1));
        check("R10 cpu0 id20 untouched", 128'({cpu_level[20], cpu_pend[20]}), 128'(0));

        // R4: pending held after fall; R6 level mode drops with line
        irq_in[NS+32+20] = 1'b0;
        irq_in[5] = 1'b0;
        cycle();
        check("R4 pend held", 128'({cpu_level[52], cpu_pend[52]}), 128'(1));
        check("R6 level pend follows", 128'(shared_pend[5]), 128'(0));

        // R7: clear together with a new rising edge, set wins
        cp_clr[52] = 1'b1;
        irq_in[NS+32+20] = 1'b1;
        cycle();
        check("R7 set beats clear", 128'(cpu_pend[52]), 128'(1));
        // R7: clear alone
        cycle();
        check("R7 clear drops", 128'(cpu_pend[52]), 128'(0));
        cp_clr[52] = 1'b0;

        // R5: falling edge on edge line never sets
        sh_edge[7] = 1'b1;
        irq_in[7] = 1'b1;
        cycle();
        sh_clr[7] = 1'b1;
        cycle();
        sh_clr[7] = 1'b0;
        irq_in[7] = 1'b0;
        cycle();
        check("R5 fall no set", 128'(shared_pend[7]), 128'(0));

        // R8: reserved line, processor 0 local ID 3
        irq_in[NS+3] = 1'b1;
        cycle();
        check("R8 flag pulses", 128'(sgi_line_err), 128'(1));
        check("R8 reserved silent", 128'({cpu_level[3], cpu_pend[3]}), 128'(0));
        // R3: no change, nothing moves
        cycle();
        check("R8 flag one cycle", 128'(sgi_line_err), 128'(0));
        check("R3 steady level", 128'(shared_level[7]), 128'(0));

        // random phase
        for (int n = 0; n < 3000; n++) begin
            if (n % 64 == 0) begin
                for (int b = 0; b < NS; b++) sh_edge[b] = 1'($urandom % 2);
                for (int b = 0; b < NP; b++) cp_edge[b] = 1'($urandom % 2);
            end
            for (int k = 0; k < NL; k++) begin
                bit rsv = (k >= NS) && (((k - NS) % 32) < 16);
                if (($urandom % (rsv ? 97 : 4)) == 0) irq_in[k] = ~irq_in[k];
            end
            for (int b = 0; b < NS; b++) sh_clr[b] = (($urandom % 8) == 0);
            for (int b = 0; b < NP; b++) cp_clr[b] = (($urandom % 8) == 0);
            cycle();
        end

        // R9: reset in mid-run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 mid reset", 128'({shared_level, shared_pend, cpu_level, cpu_pend, sgi_line_err}), 128'(0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule